// File: doc/BRIEF.md
# Output Drive Impedance Step Controller

This block keeps the drive-strength code of an output driver moving toward a requested code. It is clocked by the main clock, but it moves the code only on a slow tick. The tick comes from an internal divider whose ratio is a parameter. On each tick the code moves exactly one LSB toward the requested target, so the driver never sees a large jump. Once the code matches the target, it holds. If the clock stops, the code stops moving. No bus cycle type or output enable signal reaches the block, so it keeps updating no matter what traffic the driver carries.

After reset the code takes a nominal value for a roughly 50-ohm driver. The requested code normally comes from an external calibration comparator that sets the target to one fifth of a reference resistor. A strap input overrides the target and forces the strongest drive code (all ones) at once. When the strap is released, the code walks back toward the requested target one step per tick. A status output shows when the code equals the target currently in force.

Top module: `zq_imp_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `drive_code` becomes NOM_CODE (20 by default) and the tick divider clears.
- R2: After reset is released, a tick occurs at every DIV_RATIO-th rising edge. The first tick is at edge DIV_RATIO. `drive_code` changes at no other edge unless the strap is active.
- R3: On a tick, `drive_code` moves by exactly one toward the effective target.
- R4: When `drive_code` equals the effective target, it holds its value across ticks.
- R5: `drive_code` saturates at 0 and at all ones and never wraps. A target of 0 drives it down to 0, where it stays.
- R6: `code_locked` is high exactly when `drive_code` equals the effective target. The effective target is `target_code`, or all ones while `min_imp_strap` is high.
- R7: While `min_imp_strap` is high at a rising edge, `drive_code` becomes all ones at that edge and stays there. The divider keeps counting during this time.
- R8: After the strap falls, `drive_code` steps down from all ones one LSB per tick toward `target_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| min_imp_strap | input | 1 | Forces the strongest drive code |
| target_code | input | CODE_W | Requested drive code from calibration |
| drive_code | output | CODE_W | Current drive-strength code |
| code_locked | output | 1 | Code equals the effective target |

## Verification
The hardest case to reach is the one where the target moves while a walk is in progress. The bench lets the code climb part of the way toward a high target, then drops the target below the current code and expects the walk to turn back one LSB at a time. A second case has the strap rising and falling in the middle of a divider period. This shows whether the first step after release lands on the divider's own schedule rather than on one that restarts from the strap. A cycle-by-cycle reference model in the bench compares the code and the lock flag on every clock.

// File: rtl/zq_pkg.sv
package zq_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } step_dir_e;

    typedef struct packed {
        logic      force_max;
        step_dir_e dir;
    } step_req_t;

    function automatic step_dir_e dir_of(input int unsigned cur, input int unsigned tgt);
        if (cur < tgt)      return DIR_UP;
        else if (cur > tgt) return DIR_DOWN;
        else                return DIR_HOLD;
    endfunction
endpackage

// File: rtl/zq_tick_div.sv
module zq_tick_div #(
    parameter int DIV_RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/zq_target_sel.sv
module zq_target_sel #(
    parameter int CODE_W = 6
) (
    input  logic                 strap,
    input  logic [CODE_W-1:0]    target_code,
    input  logic [CODE_W-1:0]    cur_code,
    output logic [CODE_W-1:0]    eff_target,
    output zq_pkg::step_req_t    req,
    output logic                 locked
);
    import zq_pkg::*;
    localparam logic [CODE_W-1:0] MAX_CODE = '1;

    always_comb begin
        eff_target    = strap ? MAX_CODE : target_code;
        req.force_max = strap;
        req.dir       = dir_of(int'(cur_code), int'(eff_target));
        locked        = (cur_code == eff_target);
    end
endmodule

// File: rtl/zq_step_unit.sv
module zq_step_unit #(
    parameter int CODE_W   = 6,
    parameter int NOM_CODE = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  zq_pkg::step_req_t req,
    input  logic [CODE_W-1:0] eff_target,
    output logic [CODE_W-1:0] code_q
);
    import zq_pkg::*;
    localparam logic [CODE_W-1:0] MAX_CODE = '1;
    localparam logic [CODE_W-1:0] NOM      = CODE_W'(NOM_CODE);

    logic [CODE_W-1:0] code_d;

    always_comb begin
        code_d = code_q;
        if (req.force_max) begin
            code_d = MAX_CODE;
        end else if (tick) begin
            unique case (req.dir)
                DIR_UP:   if (code_q != MAX_CODE) code_d = code_q + 1'b1;
                DIR_DOWN: if (code_q != '0)       code_d = code_q - 1'b1;
                default:  code_d = code_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) code_q <= NOM;
        else     code_q <= code_d;
    end

    // R2
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req.force_max) && (code_q != $past(code_q))) |-> $past(tick));

    // R3
    one_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req.force_max) && $past(tick) && ($past(code_q) != $past(eff_target)))
        |-> ((code_q == CODE_W'($past(code_q) + 1'b1)) || (code_q == CODE_W'($past(code_q) - 1'b1))));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req.force_max) && ($past(code_q) == $past(eff_target))) |-> $stable(code_q));

    // R7
    force_max_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req.force_max)) |-> (code_q == MAX_CODE));
endmodule

// File: rtl/zq_imp_ctrl.sv
module zq_imp_ctrl #(
    parameter int CODE_W    = 6,
    parameter int DIV_RATIO = 16,
    parameter int NOM_CODE  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              min_imp_strap,
    input  logic [CODE_W-1:0] target_code,
    output logic [CODE_W-1:0] drive_code,
    output logic              code_locked
);
    import zq_pkg::*;

    logic              tick;
    logic [CODE_W-1:0] eff_target;
    step_req_t         req;

    zq_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    zq_target_sel #(.CODE_W(CODE_W)) u_sel (
        .strap       (min_imp_strap),
        .target_code (target_code),
        .cur_code    (drive_code),
        .eff_target  (eff_target),
        .req         (req),
        .locked      (code_locked)
    );

    zq_step_unit #(.CODE_W(CODE_W), .NOM_CODE(NOM_CODE)) u_step (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .req        (req),
        .eff_target (eff_target),
        .code_q     (drive_code)
    );

    // R1
    reset_nom_chk: assert property (@(posedge clk)
        $past(rst) |-> (drive_code == CODE_W'(NOM_CODE)));
endmodule

// File: tb/test_zq_imp_ctrl.sv
module test_zq_imp_ctrl;
    localparam int W   = 6;
    localparam int DIV = 4;
    localparam int NOM = 20;
    localparam logic [W-1:0] MAXC = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strap = 1'b0;
    logic [W-1:0] target = W'(NOM);
    logic [W-1:0] code;
    logic locked;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    zq_imp_ctrl #(.CODE_W(W), .DIV_RATIO(DIV), .NOM_CODE(NOM)) i_zq_imp_ctrl (
        .clk           (clk),
        .rst           (rst),
        .min_imp_strap (strap),
        .target_code   (target),
        .drive_code    (code),
        .code_locked   (locked)
    );

    // Reference model built from R1..R8
    int unsigned  mcnt;
    logic [W-1:0] mcode;
    always @(posedge clk) begin
        if (rst) begin
            mcnt  <= 0;
            mcode <= W'(NOM);
        end else begin
            if (strap) mcode <= MAXC;
            else if (mcnt == DIV - 1) begin
                if (mcode < target && mcode != MAXC) mcode <= mcode + 1'b1;
                else if (mcode > target && mcode != 0) mcode <= mcode - 1'b1;
            end
            mcnt <= (mcnt == DIV - 1) ? 0 : mcnt + 1;
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare every cycle, a quarter period after the rising edge
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1.2;
            check({tag, " code"}, code, mcode);
            check({tag, " R6 lock"}, W'(locked), W'(mcode == (strap ? MAXC : target)));
        end
    endtask

    task automatic drive(input logic s, input logic [W-1:0] t);
        @(negedge clk);
        strap  = s;
        target = t;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #0.5;
        check("R1 reset code", code, W'(NOM));
        check("R1 R6 lock at nominal", W'(locked), W'(target == W'(NOM)));
    endtask

    task automatic t_step_up;
        drive(1'b0, 6'd30);
        run(DIV * 3, "R2 R3 up");
        check("R3 three ticks up", code, W'(NOM + 3));
        run(DIV * 12, "R4 up hold");
        check("R4 held at target", code, 6'd30);
        check("R6 locked", W'(locked), 6'd1);
    endtask

    task automatic t_reverse;
        drive(1'b0, 6'd50);
        run(DIV * 5 + 2, "R3 climb");
        drive(1'b0, 6'd28);
        run(DIV * 12, "R3 reverse");
        check("R3 R4 reversed to target", code, 6'd28);
    endtask

    task automatic t_floor;
        drive(1'b0, 6'd0);
        run(DIV * 34, "R5 floor");
        check("R5 at zero", code, 6'd0);
        run(DIV * 3, "R5 no wrap");
        check("R5 still zero", code, 6'd0);
    endtask

    task automatic t_ceiling;
        drive(1'b0, MAXC);
        run(DIV * 66, "R5 ceiling");
        check("R5 at max", code, MAXC);
    endtask

    task automatic t_strap;
        drive(1'b0, 6'd10);
        run(DIV * 2 + 1, "R8 pre");
        drive(1'b1, 6'd10);
        run(1, "R7 strap");
        check("R7 forced max", code, MAXC);
        check("R7 R6 locked", W'(locked), 6'd1);
        run(DIV * 2 + 1, "R7 strap hold");
        drive(1'b0, 6'd10);
        run(DIV * 3, "R8 release");
        check("R8 three steps down", code, MAXC - 6'd3);
        run(DIV * 60, "R8 settle");
        check("R8 settled", code, 6'd10);
    endtask

    task automatic t_reset_mid;
        drive(1'b0, 6'd40);
        run(DIV * 5, "R1 pre");
        t_reset();
        run(DIV - 1, "R2 first tick wait");
        check("R2 no step before tick", code, W'(NOM));
        run(1, "R2 first tick");
        check("R2 first step", code, W'(NOM + 1));
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        t_reset();
        t_step_up();
        t_reverse();
        t_floor();
        t_ceiling();
        t_strap();
        t_reset_mid();
        finish_up();
    end
endmodule